// File: doc/BRIEF.md
# ADC Scan Sequencer Controller

This block is the digital control side of an eight-channel analog-to-digital converter. It walks the converter core over a chosen set of channels. It hands the core a channel number and holds a request until the core signals done. It then stores each 10-bit result in that channel's register and raises a one-cycle done flag for the channel.

Software controls the block through a single control-word write. The word starts or aborts a scan, picks one-shot or repeating scans, enables starting on the rising and/or falling edge of an external trigger, and selects the divisor of a clock-enable prescaler that paces the converter. External trigger edges go through a two-flop synchronizer. A qualifying edge starts a scan exactly as a software start does, and it also produces a one-cycle capture pulse. Start requests that arrive while a scan is active are ignored.

Top module: `adc_scan_ctrl`

## Requirements
- R1: A control write with bit 0 (start) set, while idle and with a nonzero channel mask, sets `busy` and asserts `conv_req` on the next clock, with `conv_chan` at the lowest selected channel. `conv_req` is never high while `busy` is low.
- R2: While `busy` is 1, start requests from software writes (bit 0 set) or from trigger edges are ignored: the scan in progress is neither restarted nor redirected.
- R3: Selected channels (bits of `chan_mask`) are converted in ascending order, and unselected channels are skipped. A start request with an all-zero mask leaves `busy` at 0.
- R4: With bit 1 (continuous) clear, `busy` returns to 0 after the result of the highest selected channel is stored, and no further requests are issued.
- R5: With bit 1 set, `busy` stays at 1 and the scan wraps from the highest selected channel back to the lowest.
- R6: A control write with bit 0 clear while `busy` is 1 aborts the scan. On the next clock `busy` and `conv_req` are 0 and `conv_chan` is 0, and the aborted channel's result register keeps its old value.
- R7: With bit 2 (rising enable) set, a rising edge on `ext_trig` acts as a start request and gives a one-cycle `capture` pulse. Both appear on the third rising clock edge after the input changes. With bit 2 clear, rising edges do nothing.
- R8: With bit 3 (falling enable) set, a falling edge on `ext_trig` behaves like the rising edge of R7, with the same latency. With bit 3 clear, falling edges do nothing.
- R9: `capture` pulses on every qualifying trigger edge, including edges that arrive while `busy` is 1 and whose start request is ignored.
- R10: `conv_ce` is a one-cycle pulse repeating every 2, 4, 6 or 8 cycles for divisor code 0, 1, 2 or 3 in control bits 5:4. Reset selects code 0.
- R11: Each `conv_done` during a scan writes `conv_result` into the register of the current channel, at `res_flat[10*i +: 10]`, and pulses bit i of `chan_done` for one cycle. Reset clears all result registers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Control word: bit0 start, bit1 continuous, bit2 rising enable, bit3 falling enable, bits5:4 divisor code |
| chan_mask | input | 8 | Channels to scan, one bit per channel |
| ext_trig | input | 1 | Asynchronous external trigger |
| busy | output | 1 | Scan active (start/status bit) |
| capture | output | 1 | One-cycle pulse on a qualifying trigger edge |
| conv_ce | output | 1 | Converter clock enable from the prescaler |
| conv_chan | output | 3 | Channel being converted |
| conv_req | output | 1 | Conversion request to the core, held until done |
| conv_done | input | 1 | Core finished the requested conversion |
| conv_result | input | 10 | Core result, valid with conv_done |
| chan_done | output | 8 | One-cycle per-channel result-stored flags |
| res_flat | output | 80 | Per-channel result registers, channel i at bits 10*i+9:10*i |

## Verification
The checker enforces several rules on every cycle. `conv_req` never rises without `busy`. A start request while busy cannot move the channel pointer, an empty mask cannot start a scan, and an abort empties the pipeline on the next clock. `chan_done` is at most one-hot and appears only after a done handshake, and `conv_ce` never lasts two cycles. Other behaviours show only in the bench's scenarios: the channel visiting order, one-shot termination against continuous wrap, the stored result values, the untouched register after an abort, the prescaler periods and the trigger latency and edge-enable selection.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
    localparam int NUM_CH = 8;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int RES_W  = 10;
    localparam int DIV_W  = 2;
    localparam int CTL_W  = 6;

    // control word field positions
    localparam int CTL_START = 0;
    localparam int CTL_CONT  = 1;
    localparam int CTL_RISE  = 2;
    localparam int CTL_FALL  = 3;
    localparam int CTL_DIV   = 4;

    typedef struct packed {
        logic [DIV_W-1:0] div_sel;
        logic             fall_en;
        logic             rise_en;
        logic             cont;
    } ctl_t;

    typedef struct packed {
        logic            found;
        logic [CH_W-1:0] idx;
    } pick_t;

    // lowest selected channel at or above 'from'
    function automatic pick_t pick_from(input logic [NUM_CH-1:0] mask, input int from);
        pick_t p;
        p = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (mask[i] && i >= from) begin
                p.found = 1'b1;
                p.idx   = CH_W'(i);
            end
        end
        return p;
    endfunction

    function automatic int divisor(input logic [DIV_W-1:0] sel);
        return 2 * (int'(sel) + 1);
    endfunction
endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge (
    input  logic clk,
    input  logic rst,
    input  logic trig_in,
    input  logic rise_en,
    input  logic fall_en,
    output logic start_o,
    output logic capture_o
);
    logic [2:0] shr;
    logic       rise, fall;

    always_ff @(posedge clk) begin
        if (rst) shr <= '0;
        else     shr <= {shr[1:0], trig_in};
    end

    assign rise    = shr[1] & ~shr[2];
    assign fall    = ~shr[1] & shr[2];
    assign start_o = (rise & rise_en) | (fall & fall_en);

    always_ff @(posedge clk) begin
        if (rst) capture_o <= 1'b0;
        else     capture_o <= start_o;
    end
endmodule

// File: rtl/adc_clk_presc.sv
module adc_clk_presc
    import adc_scan_pkg::*;
#(
    parameter int SEL_W = DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] div_sel,
    output logic             ce_o
);
    localparam int MAX_DIV = 2 * (2 ** SEL_W);
    localparam int CNT_W   = $clog2(MAX_DIV);

    logic [CNT_W-1:0] cnt;
    int               last;

    assign last = divisor(div_sel) - 1;
    assign ce_o = (int'(cnt) == last);

    always_ff @(posedge clk) begin
        if (rst)                    cnt <= '0;
        else if (int'(cnt) >= last) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int N_CH = 8,
    parameter int R_W  = 10,
    parameter int I_W  = $clog2(N_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [I_W-1:0]    wr_idx,
    input  logic [R_W-1:0]    wr_data,
    output logic [N_CH*R_W-1:0] res_flat,
    output logic [N_CH-1:0]   done_flags
);
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic          hit;
        logic [R_W-1:0] res_q;
        assign hit = wr_en && (int'(wr_idx) == g);
        always_ff @(posedge clk) begin
            if (rst) begin
                res_q         <= '0;
                done_flags[g] <= 1'b0;
            end else begin
                done_flags[g] <= hit;
                if (hit) res_q <= wr_data;
            end
        end
        assign res_flat[g*R_W +: R_W] = res_q;
    end
endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
    import adc_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic              abort,
    input  logic              cont,
    input  logic [NUM_CH-1:0] mask,
    input  logic              conv_done,
    output logic              busy,
    output logic              req,
    output logic [CH_W-1:0]   ptr,
    output logic              wr_en
);
    pick_t first, nxt;

    assign first = pick_from(mask, 0);
    assign nxt   = pick_from(mask, int'(ptr) + 1);
    assign wr_en = busy && req && conv_done && !abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            req  <= 1'b0;
            ptr  <= '0;
        end else if (busy && abort) begin
            busy <= 1'b0;
            req  <= 1'b0;
            ptr  <= '0;
        end else if (!busy) begin
            if (start_req && first.found) begin
                busy <= 1'b1;
                req  <= 1'b1;
                ptr  <= first.idx;
            end
        end else if (req) begin
            if (conv_done) begin
                req <= 1'b0;
                if (nxt.found) begin
                    ptr <= nxt.idx;
                end else if (cont && first.found) begin
                    ptr <= first.idx;
                end else begin
                    busy <= 1'b0;
                    ptr  <= '0;
                end
            end
        end else begin
            req <= 1'b1;
        end
    end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ctl_we,
    input  logic [CTL_W-1:0]        ctl_wdata,
    input  logic [NUM_CH-1:0]       chan_mask,
    input  logic                    ext_trig,
    output logic                    busy,
    output logic                    capture,
    output logic                    conv_ce,
    output logic [CH_W-1:0]         conv_chan,
    output logic                    conv_req,
    input  logic                    conv_done,
    input  logic [RES_W-1:0]        conv_result,
    output logic [NUM_CH-1:0]       chan_done,
    output logic [NUM_CH*RES_W-1:0] res_flat
);
    ctl_t ctl_q;
    logic ext_start, sw_start, sw_abort, wr_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (ctl_we) begin
            ctl_q.cont    <= ctl_wdata[CTL_CONT];
            ctl_q.rise_en <= ctl_wdata[CTL_RISE];
            ctl_q.fall_en <= ctl_wdata[CTL_FALL];
            ctl_q.div_sel <= ctl_wdata[CTL_DIV +: DIV_W];
        end
    end

    assign sw_start = ctl_we &  ctl_wdata[CTL_START];
    assign sw_abort = ctl_we & ~ctl_wdata[CTL_START];

    adc_trig_edge u_trig (
        .clk(clk), .rst(rst), .trig_in(ext_trig),
        .rise_en(ctl_q.rise_en), .fall_en(ctl_q.fall_en),
        .start_o(ext_start), .capture_o(capture)
    );

    adc_clk_presc #(.SEL_W(DIV_W)) u_presc (
        .clk(clk), .rst(rst), .div_sel(ctl_q.div_sel), .ce_o(conv_ce)
    );

    adc_scan_fsm u_fsm (
        .clk(clk), .rst(rst), .start_req(sw_start | ext_start),
        .abort(sw_abort), .cont(ctl_q.cont), .mask(chan_mask),
        .conv_done(conv_done), .busy(busy), .req(conv_req),
        .ptr(conv_chan), .wr_en(wr_en)
    );

    adc_result_bank #(.N_CH(NUM_CH), .R_W(RES_W), .I_W(CH_W)) u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(conv_chan),
        .wr_data(conv_result), .res_flat(res_flat), .done_flags(chan_done)
    );
endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk
    import adc_scan_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ctl_we,
    input logic [CTL_W-1:0]  ctl_wdata,
    input logic [NUM_CH-1:0] chan_mask,
    input logic              busy,
    input logic              conv_req,
    input logic              conv_done,
    input logic [CH_W-1:0]   conv_chan,
    input logic [NUM_CH-1:0] chan_done,
    input logic              conv_ce
);
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst) !busy |-> !conv_req); // R1
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
        busy && ctl_we && ctl_wdata[CTL_START] && !conv_done |=> conv_chan == $past(conv_chan)); // R2
    AST_EMPTY_MASK_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy && chan_mask == '0 |=> !busy); // R3
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        busy && ctl_we && !ctl_wdata[CTL_START] |=> !busy && !conv_req && conv_chan == '0); // R6
    AST_CE_SINGLE: assert property (@(posedge clk) disable iff (rst) conv_ce |=> !conv_ce); // R10
    AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(chan_done)); // R11
    AST_DONE_CAUSED: assert property (@(posedge clk) disable iff (rst)
        chan_done != '0 |-> $past(conv_done) && $past(busy)); // R11
endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .chan_mask(chan_mask), .busy(busy), .conv_req(conv_req),
    .conv_done(conv_done), .conv_chan(conv_chan), .chan_done(chan_done),
    .conv_ce(conv_ce)
);

// File: tb/adc_scan_ctrl_bench.sv
module adc_scan_ctrl_bench;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [5:0]  ctl_wdata = '0;
    logic [7:0]  chan_mask = '0;
    logic        ext_trig = 1'b0;
    logic        busy, capture, conv_ce, conv_req;
    logic [2:0]  conv_chan;
    logic        conv_done;
    logic [9:0]  conv_result;
    logic [7:0]  chan_done;
    logic [79:0] res_flat;

    int checks = 0, fails = 0;
    int base = 100;
    int log_ch [256];
    int log_n = 0;
    int done_cnt [8];
    int cap_cnt = 0;
    int lat = 0;

    // prescaler vectors: code, expected period
    localparam int VEC_N = 4;
    localparam int VEC_CODE [VEC_N] = '{2, 0, 3, 1};
    localparam int VEC_PER  [VEC_N] = '{6, 2, 8, 4};

    always #4 clk = ~clk;

    adc_scan_ctrl u_adc_scan_ctrl (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .chan_mask(chan_mask), .ext_trig(ext_trig), .busy(busy),
        .capture(capture), .conv_ce(conv_ce), .conv_chan(conv_chan),
        .conv_req(conv_req), .conv_done(conv_done), .conv_result(conv_result),
        .chan_done(chan_done), .res_flat(res_flat)
    );

    // converter core model
    initial begin
        conv_done = 1'b0;
        conv_result = '0;
        forever begin
            @(negedge clk);
            conv_done = 1'b0;
            if (conv_req && !rst) begin
                if (lat == LAT - 1) begin
                    conv_done = 1'b1;
                    conv_result = 10'(base + int'(conv_chan) * 7);
                    log_ch[log_n] = int'(conv_chan);
                    log_n++;
                    lat = 0;
                end else lat++;
            end else lat = 0;
        end
    end

    // pulse monitors
    initial begin
        for (int i = 0; i < 8; i++) done_cnt[i] = 0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                for (int i = 0; i < 8; i++) if (chan_done[i]) done_cnt[i]++;
                if (capture) cap_cnt++;
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int res_of(input int ch);
        return int'(res_flat[ch*10 +: 10]);
    endfunction

    task automatic wr_ctl(input logic [5:0] d);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = d;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    endtask

    task automatic measure(output int per);
        per = 0;
        for (int i = 0; i < 20 && !conv_ce; i++) @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            per++;
            if (conv_ce) break;
        end
    endtask

    task automatic set_trig(input logic v);
        @(negedge clk);
        ext_trig = v;
    endtask

    initial begin
        int per, n0, c, old, cap0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        chk(!busy && !conv_req && !capture, "R1", "reset busy/req/capture", int'(busy), 0);
        chk(res_flat == '0, "R11", "reset results", res_of(0), 0);
        measure(per); measure(per);
        chk(per == 2, "R10", "reset divisor period", per, 2);

        // prescaler vector table
        for (int v = 0; v < VEC_N; v++) begin
            wr_ctl(6'(VEC_CODE[v] << 4));
            measure(per); measure(per);
            chk(per == VEC_PER[v], "R10", "prescaler period", per, VEC_PER[v]);
        end
        wr_ctl(6'b000000);

        // one-time scan over 0,2,5,7
        chan_mask = 8'hA5;
        base = 100;
        n0 = log_n;
        wr_ctl(6'b000001);
        chk(busy && conv_req && conv_chan == 3'd0, "R1", "start first channel", int'(conv_chan), 0);
        for (int i = 0; i < 100 && log_n < n0 + 1; i++) @(negedge clk);
        wr_ctl(6'b000001); // restart attempt while busy
        wait_idle();
        chk(!busy, "R4", "one-time scan ends", int'(busy), 0);
        chk(log_n - n0 == 4, "R2", "no restart while busy", log_n - n0, 4);
        chk(log_ch[n0] == 0 && log_ch[n0+1] == 2 && log_ch[n0+2] == 5 && log_ch[n0+3] == 7,
            "R3", "ascending order, skip", log_ch[n0+2], 5);
        chk(res_of(5) == 135 && res_of(7) == 149, "R11", "stored results", res_of(5), 135);
        chk(done_cnt[2] == 1 && done_cnt[1] == 0 && done_cnt[7] == 1, "R11", "done flags", done_cnt[2], 1);
        repeat (6) @(negedge clk);
        chk(log_n - n0 == 4 && !conv_req, "R4", "no request after end", log_n - n0, 4);

        // empty mask
        chan_mask = 8'h00;
        wr_ctl(6'b000001);
        chk(!busy && !conv_req, "R3", "empty mask start ignored", int'(busy), 0);

        // continuous over 1,4, then abort
        chan_mask = 8'h12;
        base = 200;
        n0 = log_n;
        wr_ctl(6'b000011);
        for (int i = 0; i < 200 && log_n < n0 + 3; i++) @(negedge clk);
        chk(busy, "R5", "continuous busy stays", int'(busy), 1);
        chk(log_ch[n0] == 1 && log_ch[n0+1] == 4 && log_ch[n0+2] == 1, "R5", "wrap to lowest",
            log_ch[n0+2], 1);
        base = 300;
        begin
            logic prev;
            prev = conv_req;
            for (int i = 0; i < 50; i++) begin
                @(negedge clk);
                if (conv_req && !prev) break;
                prev = conv_req;
            end
        end
        c = int'(conv_chan);
        old = res_of(c);
        n0 = log_n;
        wr_ctl(6'b000010);
        chk(!busy && !conv_req && conv_chan == 3'd0, "R6", "abort clears", int'(busy), 0);
        repeat (8) @(negedge clk);
        chk(res_of(c) == old && log_n == n0, "R6", "aborted result kept", res_of(c), old);

        // trigger edges, enables clear
        chan_mask = 8'h01;
        base = 50;
        wr_ctl(6'b000000);
        cap0 = cap_cnt;
        set_trig(1'b1);
        repeat (5) @(negedge clk);
        chk(!busy && cap_cnt == cap0, "R7", "rising ignored when disabled", cap_cnt - cap0, 0);
        wr_ctl(6'b000100);
        set_trig(1'b0);
        repeat (5) @(negedge clk);
        chk(!busy && cap_cnt == cap0, "R8", "falling ignored when disabled", cap_cnt - cap0, 0);
        set_trig(1'b1);
        repeat (3) @(negedge clk);
        chk(capture && busy, "R7", "rising edge start+capture", int'(capture), 1);
        @(negedge clk);
        chk(!capture, "R7", "capture one cycle", int'(capture), 0);
        wait_idle();

        // falling enabled, continuous, edge while busy
        wr_ctl(6'b001010);
        cap0 = cap_cnt;
        set_trig(1'b0);
        repeat (3) @(negedge clk);
        chk(capture && busy, "R8", "falling edge start+capture", int'(capture), 1);
        set_trig(1'b1);
        repeat (4) @(negedge clk);
        set_trig(1'b0);
        repeat (4) @(negedge clk);
        chk(cap_cnt - cap0 == 2 && busy, "R9", "capture while busy", cap_cnt - cap0, 2);
        wr_ctl(6'b001010);
        chk(!busy, "R6", "abort of triggered scan", int'(busy), 0);

        summary();
        $finish;
    end
endmodule